// File: doc/BRIEF.md
# Indirect Bus-Access Command Bridge

This block lets a host that only speaks 64-bit register transactions perform single reads and writes on an internal peripheral bus with a 32-bit address. The host fills a data register, writes one command word holding the direction, the byte count and the target address, and later collects the outcome from a status word. Reading the status word clears it.

The register side is a one-cycle access port with four 64-bit registers, chosen by address bits [4:3]: 0 control, 1 reset, 2 status, 3 data. Read data is combinational during the access cycle. Any side effect of the access, such as loading or clearing a register, takes place at the clock edge that ends the cycle. The bus side issues a valid/ready request and then waits for a response carrying read data and an error bit. That response must arrive at least one cycle after the request is accepted. Only one access may be outstanding. The `busy` output shows when one is in flight.

Top module: `cmdbr_top`

## Requirements
- R1: A register access takes effect only when all eight byte enables are high and address bits [2:0] are zero. Any other access changes nothing and reads zero. Reading the control register (select 0) or the reset register (select 1) returns zero.
- R2: A full write to the data register (select 3) stores bits [63:32] of the written word. A read of it returns the stored value in [63:32] with zeros in [31:0].
- R3: In the control word, bit 48 set means read and clear means write. Bits [59:56] hold the byte count and bits [31:0] the bus address. A launched command presents these on `bus_addr`, `bus_write` (high for a write) and `bus_nbytes`.
- R4: A control write whose byte count is above 8 launches nothing and leaves the status register unchanged. A count of exactly 8 is accepted.
- R5: A write command drives the stored data register on `bus_wdata`, with the first byte in [31:24]. On its response, status becomes 64'h800 (done flag at bit 11 only), whether or not the error bit is set.
- R6: A successful read loads status with the done flag at bit 11 and the fetched word at [57:26], the first byte fetched being the most significant. Bytes beyond the byte count read as zero.
- R7: A read answered with the error bit loads status with the done flag and all ones in [57:26].
- R8: A full read of the status register (select 2) returns its value and clears it to zero at the end of the access. If a completion lands in the same cycle, the new completion value is kept instead.
- R9: Writes to the status and reset registers change nothing.
- R10: `busy` rises the cycle after a launch and falls the cycle after the response. Control writes made while busy are ignored.
- R11: While `bus_req_valid` is high and `bus_req_ready` is low, the request and its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte address; [4:3] selects the register |
| reg_be | input | 8 | Byte enables, all must be high |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (same cycle) |
| busy | output | 1 | An access is outstanding |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_addr | output | 32 | Bus address |
| bus_write | output | 1 | 1 = write request |
| bus_nbytes | output | 4 | Byte count |
| bus_wdata | output | 32 | Write data, first byte in [31:24] |
| bus_rsp_valid | input | 1 | Bus response valid |
| bus_rsp_rdata | input | 32 | Read data, first byte in [31:24] |
| bus_rsp_err | input | 1 | Response error |

## Verification
The assertions check the following on every cycle:
- the bus request holds steady under backpressure;
- `busy` only rises after a launch and only falls after a response;
- the status word clears after a read, keeps a completion that lands in the same cycle, and otherwise holds;
- write and error completions produce the right status patterns;
- oversized commands never launch.

Only the bench scenarios can show the rest:
- the field decode of the command word;
- byte masking for short reads and the byte order of the data word;
- that partial-enable accesses and writes to status or reset have no effect;
- that a second command issued while busy is dropped.

// File: rtl/cmdbr_pkg.sv
package cmdbr_pkg;
  localparam int WORD_W        = 64;
  localparam int BUS_AW        = 32;
  localparam int BUS_DW        = 32;
  localparam int SZ_W          = 4;
  localparam int CMD_RD_BIT    = 48;
  localparam int CMD_SZ_LSB    = 56;
  localparam int STAT_DONE_BIT = 11;
  localparam int STAT_DATA_LSB = 26;
  localparam int DATA_REG_LSB  = 32;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } regsel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic              is_read;
    logic [SZ_W-1:0]   nbytes;
    logic [BUS_AW-1:0] addr;
  } cmd_t;

  // Keep the first n bytes of a big-endian word, zero the rest.
  function automatic logic [BUS_DW-1:0] keep_bytes(input logic [BUS_DW-1:0] d,
                                                   input logic [SZ_W-1:0]   n);
    logic [BUS_DW-1:0] r;
    r = '0;
    for (int i = 0; i < BUS_DW/8; i++) begin
      if (n > SZ_W'(i)) r[BUS_DW-1-8*i -: 8] = d[BUS_DW-1-8*i -: 8];
    end
    return r;
  endfunction

  // Completion status word: done flag, optionally with a data field.
  function automatic logic [WORD_W-1:0] stat_word(input logic              with_data,
                                                  input logic [BUS_DW-1:0] d);
    logic [WORD_W-1:0] w;
    w = '0;
    w[STAT_DONE_BIT] = 1'b1;
    if (with_data) w[STAT_DATA_LSB +: BUS_DW] = d;
    return w;
  endfunction
endpackage

// File: rtl/cmdbr_decode.sv
module cmdbr_decode
  import cmdbr_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic              rd_flag,
  input  logic [SZ_W-1:0]   size_field,
  input  logic [BUS_AW-1:0] addr_field,
  output cmd_t              cmd,
  output logic              size_ok
);
  localparam logic [SZ_W-1:0] SZ_LIMIT = SZ_W'(MAX_BYTES);

  always_comb begin
    cmd.is_read = rd_flag;
    cmd.nbytes  = size_field;
    cmd.addr    = addr_field;
    size_ok     = (size_field <= SZ_LIMIT);
  end
endmodule

// File: rtl/cmdbr_engine.sv
module cmdbr_engine
  import cmdbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  cmd_t              cmd,
  input  logic [BUS_DW-1:0] wdata_in,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [BUS_AW-1:0] bus_addr,
  output logic              bus_write,
  output logic [SZ_W-1:0]   bus_nbytes,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_rsp_valid,
  input  logic [BUS_DW-1:0] bus_rsp_rdata,
  input  logic              bus_rsp_err,
  output logic              busy,
  output logic              done,
  output logic              done_is_rd,
  output logic [BUS_DW-1:0] done_rdata
);
  xfer_state_e       state_q;
  logic [BUS_AW-1:0] addr_q;
  logic              write_q;
  logic [SZ_W-1:0]   nbytes_q;
  logic [BUS_DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      write_q  <= 1'b0;
      nbytes_q <= '0;
      wdata_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch) begin
          state_q  <= ST_REQ;
          addr_q   <= cmd.addr;
          write_q  <= ~cmd.is_read;
          nbytes_q <= cmd.nbytes;
          wdata_q  <= wdata_in;
        end
        ST_REQ:  if (bus_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (bus_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign bus_req_valid = (state_q == ST_REQ);
  assign bus_addr      = addr_q;
  assign bus_write     = write_q;
  assign bus_nbytes    = nbytes_q;
  assign bus_wdata     = wdata_q;

  assign done       = (state_q == ST_WAIT) && bus_rsp_valid;
  assign done_is_rd = ~write_q;
  assign done_rdata = bus_rsp_err ? '1 : keep_bytes(bus_rsp_rdata, nbytes_q);

  // R11: request fields hold under backpressure
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_addr) &&
      $stable(bus_write) && $stable(bus_nbytes) && $stable(bus_wdata));

  // R10: busy begins only after a launch
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));

  // R10: busy ends only after a response
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bus_rsp_valid));
endmodule

// File: rtl/cmdbr_status.sv
module cmdbr_status
  import cmdbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              clr,
  output logic [WORD_W-1:0] stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= '0;
    else if (load) stat_q <= load_val;
    else if (clr)  stat_q <= '0;
  end

  // R8: a read with no completion clears the word
  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !load |=> stat_q == '0);

  // R8: a completion wins over a same-cycle clear
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> stat_q == $past(load_val));

  // R9: without load or read the word holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !clr |=> $stable(stat_q));
endmodule

// File: rtl/cmdbr_top.sv
module cmdbr_top
  import cmdbr_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [7:0]  reg_be,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        busy,
  output logic        bus_req_valid,
  input  logic        bus_req_ready,
  output logic [31:0] bus_addr,
  output logic        bus_write,
  output logic [3:0]  bus_nbytes,
  output logic [31:0] bus_wdata,
  input  logic        bus_rsp_valid,
  input  logic [31:0] bus_rsp_rdata,
  input  logic        bus_rsp_err
);
  localparam logic [WORD_W-1:0] DONE_ONLY = stat_word(1'b0, '0);

  regsel_e           sel;
  logic              acc, ctl_wr, data_wr, stat_rd, launch, size_ok;
  cmd_t              cmd;
  logic [BUS_DW-1:0] data_q;
  logic              done, done_is_rd;
  logic [BUS_DW-1:0] done_rdata;
  logic [WORD_W-1:0] stat_q, stat_load_val;

  assign sel     = regsel_e'(reg_addr[4:3]);
  assign acc     = reg_en && (&reg_be) && (reg_addr[2:0] == 3'b000);
  assign ctl_wr  = acc && reg_we && (sel == SEL_CTL);
  assign data_wr = acc && reg_we && (sel == SEL_DATA);
  assign stat_rd = acc && !reg_we && (sel == SEL_STAT);
  assign launch  = ctl_wr && size_ok && !busy;

  cmdbr_decode #(.MAX_BYTES(MAX_BYTES)) u_dec (
    .rd_flag    (reg_wdata[CMD_RD_BIT]),
    .size_field (reg_wdata[CMD_SZ_LSB +: SZ_W]),
    .addr_field (reg_wdata[BUS_AW-1:0]),
    .cmd        (cmd),
    .size_ok    (size_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_wr) data_q <= reg_wdata[DATA_REG_LSB +: BUS_DW];
  end

  cmdbr_engine u_eng (
    .clk, .rst_n, .launch, .cmd,
    .wdata_in      (data_q),
    .bus_req_valid, .bus_req_ready, .bus_addr, .bus_write, .bus_nbytes,
    .bus_wdata, .bus_rsp_valid, .bus_rsp_rdata, .bus_rsp_err,
    .busy, .done, .done_is_rd, .done_rdata
  );

  assign stat_load_val = stat_word(done_is_rd, done_rdata);

  cmdbr_status u_stat (
    .clk, .rst_n,
    .load     (done),
    .load_val (stat_load_val),
    .clr      (stat_rd),
    .stat_q   (stat_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (acc && !reg_we) begin
      unique case (sel)
        SEL_STAT: reg_rdata = stat_q;
        SEL_DATA: reg_rdata = {data_q, 32'h0};
        default:  reg_rdata = '0;
      endcase
    end
  end

  // R4: oversized command from idle never launches
  assert_oversize_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && reg_we && (&reg_be) && reg_addr == 5'd0 && !busy &&
      reg_wdata[59:56] > 4'(MAX_BYTES) |=> !busy);

  // R5: write completion leaves the done flag only
  assert_write_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_is_rd |=> stat_q == DONE_ONLY);

  // R7: failed read loads all ones in the data field
  assert_rd_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_is_rd && bus_rsp_err |=> stat_q[57:26] == '1 && stat_q[11]);
endmodule

// File: tb/sim_cmdbr_top.sv
`timescale 1ns/1ps
module sim_cmdbr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_be = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        busy, bus_req_valid, bus_write;
  logic        bus_req_ready = 1'b0;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_nbytes;
  logic        bus_rsp_valid = 1'b0;
  logic [31:0] bus_rsp_rdata = '0;
  logic        bus_rsp_err = 1'b0;

  int tests = 0, fails = 0;

  // responder configuration and captured request
  int          stall_cfg = 0;
  logic [31:0] rsp_data_cfg = '0;
  logic        rsp_err_cfg = 1'b0;
  logic [31:0] cap_addr, cap_wdata;
  logic        cap_write;
  logic [3:0]  cap_nbytes;
  int          txn_cnt = 0;

  always #10 clk = ~clk;

  cmdbr_top u0 (.*);

  localparam logic [4:0] A_CTL = 5'h00, A_RST = 5'h08, A_STAT = 5'h10, A_DATA = 5'h18;
  localparam logic [63:0] DONE = 64'h800;

  function automatic logic [63:0] ctl(input bit rd, input logic [3:0] n, input logic [31:0] a);
    return (64'(rd) << 48) | (64'(n) << 56) | 64'(a);
  endfunction
  function automatic logic [63:0] rd_stat(input logic [31:0] d);
    return (64'(d) << 26) | DONE;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [63:0] d, input logic [7:0] be = 8'hFF);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(posedge clk); #1;
    reg_en = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [63:0] d, input logic [7:0] be = 8'hFF);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a; reg_be = be;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  // bus responder
  initial begin
    int phase = 0, st = 0;
    forever begin
      @(negedge clk);
      case (phase)
        0: begin
          bus_req_ready = 0; bus_rsp_valid = 0;
          if (bus_req_valid) begin
            if (st < stall_cfg) st++;
            else begin
              st = 0; bus_req_ready = 1;
              cap_addr = bus_addr; cap_write = bus_write;
              cap_nbytes = bus_nbytes; cap_wdata = bus_wdata;
              phase = 1;
            end
          end
        end
        1: begin
          bus_req_ready = 0; bus_rsp_valid = 1;
          bus_rsp_rdata = rsp_data_cfg; bus_rsp_err = rsp_err_cfg;
          phase = 2;
        end
        default: begin
          bus_rsp_valid = 0; bus_rsp_err = 0; txn_cnt++; phase = 0;
        end
      endcase
    end
  end

  task automatic t_reset();
    logic [63:0] v;
    check("R10 busy after reset", 64'(busy), 0);
    check("R11 valid after reset", 64'(bus_req_valid), 0);
    reg_rd(A_STAT, v); check("R8 status after reset", v, 0);
    reg_rd(A_DATA, v); check("R2 data after reset", v, 0);
  endtask

  task automatic t_data_reg();
    logic [63:0] v;
    reg_wr(A_DATA, 64'hA1B2C3D4_55667788);
    reg_rd(A_DATA, v); check("R2 data readback", v, 64'hA1B2C3D4_00000000);
  endtask

  task automatic t_write_cmd();
    logic [63:0] v;
    rsp_err_cfg = 0;
    reg_wr(A_CTL, ctl(0, 4'd4, 32'h1234_5678));
    check("R10 busy after launch", 64'(busy), 1);
    wait_idle();
    check("R3 write addr", 64'(cap_addr), 64'h1234_5678);
    check("R3 write flag", 64'(cap_write), 1);
    check("R3 write nbytes", 64'(cap_nbytes), 4);
    check("R5 write data order", 64'(cap_wdata), 64'hA1B2C3D4);
    reg_rd(A_STAT, v); check("R5 write status", v, DONE);
    reg_rd(A_STAT, v); check("R8 cleared after read", v, 0);
  endtask

  task automatic t_read_ok();
    logic [63:0] v;
    rsp_data_cfg = 32'hDEADBEEF; rsp_err_cfg = 0;
    reg_wr(A_CTL, ctl(1, 4'd4, 32'h0000_00F0));
    wait_idle();
    check("R3 read flag", 64'(cap_write), 0);
    check("R3 read addr", 64'(cap_addr), 64'hF0);
    reg_rd(A_STAT, v); check("R6 read status", v, rd_stat(32'hDEADBEEF));
    rsp_data_cfg = 32'h11223344;
    reg_wr(A_CTL, ctl(1, 4'd2, 32'h0000_0010));
    wait_idle();
    reg_rd(A_STAT, v); check("R6 short read mask", v, rd_stat(32'h11220000));
  endtask

  task automatic t_errors();
    logic [63:0] v;
    rsp_err_cfg = 1; rsp_data_cfg = 32'h0;
    reg_wr(A_CTL, ctl(1, 4'd4, 32'h40));
    wait_idle();
    reg_rd(A_STAT, v); check("R7 read error status", v, rd_stat(32'hFFFFFFFF));
    reg_wr(A_CTL, ctl(0, 4'd1, 32'h44));
    wait_idle();
    reg_rd(A_STAT, v); check("R5 write error status", v, DONE);
    rsp_err_cfg = 0;
  endtask

  task automatic t_oversize();
    logic [63:0] v;
    int n0;
    rsp_data_cfg = 32'h0BADF00D;
    reg_wr(A_CTL, ctl(1, 4'd8, 32'h80));
    check("R4 size 8 accepted", 64'(busy), 1);
    wait_idle();
    n0 = txn_cnt;
    reg_wr(A_CTL, ctl(1, 4'd9, 32'h84));
    check("R4 size 9 busy", 64'(busy), 0);
    repeat (4) @(negedge clk);
    check("R4 size 9 no request", 64'(txn_cnt), 64'(n0));
    reg_rd(A_STAT, v); check("R4 status unchanged", v, rd_stat(32'h0BADF00D));
  endtask

  task automatic t_busy_ignore();
    int n0;
    n0 = txn_cnt; stall_cfg = 5;
    reg_wr(A_CTL, ctl(0, 4'd4, 32'hAAAA_0000));
    reg_wr(A_CTL, ctl(0, 4'd4, 32'hBBBB_0000));
    check("R11 valid held under stall", 64'(bus_req_valid), 1);
    check("R11 addr held under stall", 64'(bus_addr), 64'hAAAA_0000);
    wait_idle();
    repeat (4) @(negedge clk);
    check("R10 one access only", 64'(txn_cnt - n0), 1);
    check("R10 first command kept", 64'(cap_addr), 64'hAAAA_0000);
    stall_cfg = 0;
  endtask

  task automatic t_ignored_writes();
    logic [63:0] v;
    // status holds DONE from previous write
    reg_wr(A_STAT, 64'h0);
    reg_wr(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_rd(A_RST, v); check("R1 reset reads zero", v, 0);
    reg_rd(A_CTL, v); check("R1 control reads zero", v, 0);
    reg_rd(A_STAT, v); check("R9 status after ignored writes", v, DONE);
  endtask

  task automatic t_partial();
    logic [63:0] v;
    reg_wr(A_DATA, 64'h0102_0304_0000_0000);
    reg_wr(A_DATA, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F);
    reg_rd(A_DATA, v); check("R1 partial write ignored", v, 64'h01020304_00000000);
    reg_wr(A_CTL, ctl(0, 4'd4, 32'h20));
    wait_idle();
    reg_rd(A_STAT, v, 8'hF0); check("R1 partial read zero", v, 0);
    reg_rd(A_STAT, v); check("R1 partial read no clear", v, DONE);
  endtask

  task automatic t_collide();
    logic [63:0] v;
    reg_wr(A_CTL, ctl(0, 4'd4, 32'h30));
    wait_idle();
    rsp_data_cfg = 32'hCAFEF00D;
    reg_wr(A_CTL, ctl(1, 4'd4, 32'h34));
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #2;
      if (bus_rsp_valid) break;
    end
    reg_en = 1; reg_we = 0; reg_addr = A_STAT; reg_be = 8'hFF;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_en = 0;
    check("R8 read in completion cycle", v, DONE);
    reg_rd(A_STAT, v); check("R8 completion wins", v, rd_stat(32'hCAFEF00D));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_data_reg();
    t_write_cmd();
    t_read_ok();
    t_errors();
    t_oversize();
    t_busy_ignore();
    t_ignored_writes();
    t_partial();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule